// File: doc/BRIEF.md
# Opposed-Counter Parity Self-Test for Wire Bundles

This block is a self-test engine for a group of interconnect wires. It owns two pattern sources that run in opposite directions. One counts upward and the other counts downward, and each appends a parity bit to its count value. Each source's word is driven onto its own set of wires under test. At the receiving end, one parity checker per bundle recomputes parity on the bits that actually arrived. Any mismatch raises a sticky fail flag. No expected responses are stored: every legal word already satisfies its parity rule. A wire stuck at a constant, or two neighbouring wires shorted together, breaks that rule on at least one pattern of the sweep.

The physical arrangement interleaves the bundles. Each wire of the up-counting bundle lies next to a wire of the down-counting bundle, so a short between neighbours couples words that move in opposite directions. A parameter selects one of two variants. The short-line variant uses 2-bit counts and four patterns, with opposite parity senses on the two bundles. The long-line variant uses 3-bit counts and eight patterns, with even parity on both bundles. A one-cycle start pulse runs one full sweep. The engine then pulses done and keeps its verdict until reset.

Top module: `xpb_routing_bist`

## Requirements
- R1: With MODE short, the up word is 3 bits: bits [2:1] hold the count and bit 0 is parity. During a sweep the count steps 0, 1, 2, 3, and bit 0 makes the number of ones in the word odd.
- R2: With MODE short, the down word is 3 bits with the same layout. During a sweep its count steps 3, 2, 1, 0, and bit 0 makes the number of ones in the word even.
- R3: With MODE long, both words are 4 bits: bits [3:1] hold the count and bit 0 makes the number of ones even. The up count steps 0 to 7 and the down count steps 7 to 0, giving eight patterns per sweep.
- R4: In each checking cycle, failUp is set when the received up word breaks the up parity rule: odd parity in short mode, even parity in long mode. failDown is set when the received down word has odd parity. The two flags are independent.
- R5: Pattern k of a sweep is driven during the (k+1)-th cycle after the edge that accepts start. The received bits are judged at the clock edge that ends that cycle, and a resulting fail is visible from the next cycle on.
- R6: A fail flag, once set, stays set through later sweeps. Only reset clears it.
- R7: done is high for exactly one cycle, the cycle right after the last pattern is judged. In that cycle the fail flags already include the last check. The engine is idle afterwards.
- R8: Outside a sweep, including the done cycle, both counts are zero and bit 0 carries that bundle's parity bit for a zero count. Received bits are ignored there, so no flag changes.
- R9: start is accepted only when idle. A start seen during a sweep or during the done cycle has no effect on the sweep length or on the drive that follows.
- R10: After reset, done and both flags are low and both buses drive their idle words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one sweep when idle |
| upDrive | output | WORD_W | Word from the up-counting source onto its wires |
| downDrive | output | WORD_W | Word from the down-counting source onto its wires |
| upRecv | input | WORD_W | Bits received at the far end of the up bundle |
| downRecv | input | WORD_W | Bits received at the far end of the down bundle |
| done | output | 1 | One-cycle end-of-sweep pulse |
| failUp | output | 1 | Sticky parity failure on the up bundle |
| failDown | output | 1 | Sticky parity failure on the down bundle |

## Verification
The final parity check and the done pulse fall together: done must appear in the same cycle that first shows a failure caused by the last pattern. The bench provokes this by enabling a stuck fault only while the last short-line pattern is on the wires. It then expects the flag and done to rise in the same cycle, with the flag still clear one cycle before. A second collision puts a start request into the done cycle itself, and the bench expects the idle word and no restart on the following cycle. Both runs are compared each clock against a behavioural model that also computes the faulted wire bundle.

// File: rtl/xpb_pkg.sv
package xpb_pkg;

  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_LONG  = 1'b1
  } mode_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic driveEn;   // a sweep pattern is on the wires this cycle
    logic checkEn;   // received bits are judged at the coming edge
  } strobe_t;

endpackage

// File: rtl/xpb_ctrl.sv
module xpb_ctrl #(
  parameter int IDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output xpb_pkg::strobe_t     strobe,
  output logic [IDX_W-1:0]     idx,
  output logic                 done
);

  localparam logic [IDX_W-1:0] LAST = '1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } state_e;

  state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            idx   <= '0;
          end
        end
        ST_RUN: begin
          if (idx == LAST) begin
            state <= ST_FIN;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.driveEn = (state == ST_RUN);
  assign strobe.checkEn = (state == ST_RUN);
  assign done           = (state == ST_FIN);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(strobe.checkEn && idx == LAST)); // R7

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.driveEn && idx != LAST && start) |=> (strobe.driveEn && idx == $past(idx) + 1'b1)); // R9

endmodule

// File: rtl/xpb_gen.sv
module xpb_gen #(
  parameter int CNT_W      = 2,
  parameter bit COUNT_DOWN = 1'b0,
  parameter bit ODD_PAR    = 1'b0,
  localparam int WORD_W    = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              driveEn,
  input  logic [CNT_W-1:0]  idx,
  output logic [WORD_W-1:0] word
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count;
  logic             parBit;

  // Down count is the complement of the index: (2^CNT_W - 1) - idx
  generate
    if (COUNT_DOWN) begin : g_down
      assign count = driveEn ? ~idx : '0;
    end else begin : g_up
      assign count = driveEn ? idx : '0;
    end
  endgenerate

  assign parBit = (^count) ^ ODD_PAR;
  assign word   = {count, parBit};

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !driveEn |-> (word[WORD_W-1:1] == '0)); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (driveEn && $past(driveEn)) |->
      (word[WORD_W-1:1] == (COUNT_DOWN ? $past(word[WORD_W-1:1]) - ONE
                                       : $past(word[WORD_W-1:1]) + ONE))); // R1

endmodule

// File: rtl/xpb_ora.sv
module xpb_ora #(
  parameter int W       = 3,
  parameter bit ODD_PAR = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         checkEn,
  input  logic [W-1:0] recv,
  output logic         fail
);

  logic parityBad;

  assign parityBad = ((^recv) != ODD_PAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail <= 1'b0;
    else if (checkEn && parityBad) fail <= 1'b1;
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail); // R6

  AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!checkEn && !fail) |=> !fail); // R8

  AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (checkEn && ((^recv) != ODD_PAR)) |=> fail); // R4

endmodule

// File: rtl/xpb_datapath.sv
module xpb_datapath #(
  parameter int CNT_W   = 2,
  parameter bit UP_ODD  = 1'b1,
  localparam int WORD_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xpb_pkg::strobe_t  strobe,
  input  logic [CNT_W-1:0]  idx,
  input  logic [WORD_W-1:0] upRecv,
  input  logic [WORD_W-1:0] downRecv,
  output logic [WORD_W-1:0] upDrive,
  output logic [WORD_W-1:0] downDrive,
  output logic              failUp,
  output logic              failDown
);

  xpb_gen #(.CNT_W(CNT_W), .COUNT_DOWN(1'b0), .ODD_PAR(UP_ODD)) u_genUp (
    .clk(clk), .rst_n(rst_n), .driveEn(strobe.driveEn), .idx(idx), .word(upDrive)
  );

  xpb_gen #(.CNT_W(CNT_W), .COUNT_DOWN(1'b1), .ODD_PAR(1'b0)) u_genDown (
    .clk(clk), .rst_n(rst_n), .driveEn(strobe.driveEn), .idx(idx), .word(downDrive)
  );

  xpb_ora #(.W(WORD_W), .ODD_PAR(UP_ODD)) u_oraUp (
    .clk(clk), .rst_n(rst_n), .checkEn(strobe.checkEn), .recv(upRecv), .fail(failUp)
  );

  xpb_ora #(.W(WORD_W), .ODD_PAR(1'b0)) u_oraDown (
    .clk(clk), .rst_n(rst_n), .checkEn(strobe.checkEn), .recv(downRecv), .fail(failDown)
  );

endmodule

// File: rtl/xpb_routing_bist.sv
module xpb_routing_bist #(
  parameter xpb_pkg::mode_e MODE = xpb_pkg::MODE_SHORT,
  localparam int CNT_W  = (MODE == xpb_pkg::MODE_LONG) ? 3 : 2,
  localparam int WORD_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [WORD_W-1:0] upDrive,
  output logic [WORD_W-1:0] downDrive,
  input  logic [WORD_W-1:0] upRecv,
  input  logic [WORD_W-1:0] downRecv,
  output logic              done,
  output logic              failUp,
  output logic              failDown
);

  localparam bit UP_ODD = (MODE == xpb_pkg::MODE_SHORT);

  xpb_pkg::strobe_t strobe;
  logic [CNT_W-1:0] idx;

  xpb_ctrl #(.IDX_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .strobe(strobe), .idx(idx), .done(done)
  );

  xpb_datapath #(.CNT_W(CNT_W), .UP_ODD(UP_ODD)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .idx(idx),
    .upRecv(upRecv), .downRecv(downRecv),
    .upDrive(upDrive), .downDrive(downDrive),
    .failUp(failUp), .failDown(failDown)
  );

endmodule

// File: tb/xpb_routing_bist_tb.sv
module xpb_routing_bist_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit cmpOn = 1'b0;

  // fault controls per instance: 0 = short, 1 = long
  logic [7:0] fMask [2] = '{8'h00, 8'h00};
  logic [7:0] fVal  [2] = '{8'h00, 8'h00};
  bit         fBr   [2] = '{1'b0, 1'b0};
  int         fBrPos[2] = '{0, 0};

  // reference state
  int refSt [2] = '{0, 0};
  int refIdx[2] = '{0, 0};
  bit refFu [2] = '{1'b0, 1'b0};
  bit refFd [2] = '{1'b0, 1'b0};

  // Wire bundle: physical order interleaves up bit k and down bit k.
  function automatic logic [7:0] wireModel(input logic [3:0] up, input logic [3:0] dn,
                                           input int w, input logic [7:0] sm,
                                           input logic [7:0] sv, input bit be, input int bp);
    logic [7:0] p;
    logic [7:0] r;
    logic a;
    p = '0;
    for (int k = 0; k < w; k++) begin
      p[2*k]   = up[k];
      p[2*k+1] = dn[k];
    end
    p = (p & ~sm) | (sv & sm);
    if (be) begin
      a = p[bp] & p[bp+1];
      p[bp]   = a;
      p[bp+1] = a;
    end
    r = '0;
    for (int k = 0; k < w; k++) begin
      r[k]   = p[2*k];
      r[4+k] = p[2*k+1];
    end
    return r;
  endfunction

  function automatic logic [3:0] expWord(input int m, input bit isUp, input int st, input int idx);
    int n;
    logic [2:0] cnt;
    logic par;
    n = (m == 1) ? 8 : 4;
    cnt = (st == 1) ? (isUp ? 3'(idx) : 3'(n - 1 - idx)) : 3'd0;
    par = (^cnt) ^ (isUp && m == 0);
    return {cnt, par};
  endfunction

  // DUT wiring
  logic [2:0] sUpD, sDnD, sUpR, sDnR;
  logic [3:0] lUpD, lDnD, lUpR, lDnR;
  logic [7:0] sRecv, lRecv;
  logic [3:0] aUp [2];
  logic [3:0] aDn [2];
  logic aDone[2], aFu[2], aFd[2];

  assign sRecv = wireModel({1'b0, sUpD}, {1'b0, sDnD}, 3, fMask[0], fVal[0], fBr[0], fBrPos[0]);
  assign lRecv = wireModel(lUpD, lDnD, 4, fMask[1], fVal[1], fBr[1], fBrPos[1]);
  assign sUpR = sRecv[2:0];
  assign sDnR = sRecv[6:4];
  assign lUpR = lRecv[3:0];
  assign lDnR = lRecv[7:4];
  assign aUp[0] = {1'b0, sUpD};
  assign aDn[0] = {1'b0, sDnD};
  assign aUp[1] = lUpD;
  assign aDn[1] = lDnD;

  xpb_routing_bist #(.MODE(xpb_pkg::MODE_SHORT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .upDrive(sUpD), .downDrive(sDnD), .upRecv(sUpR), .downRecv(sDnR),
    .done(aDone[0]), .failUp(aFu[0]), .failDown(aFd[0])
  );

  xpb_routing_bist #(.MODE(xpb_pkg::MODE_LONG)) u_dutLong (
    .clk(clk), .rst_n(rst_n), .start(start),
    .upDrive(lUpD), .downDrive(lDnD), .upRecv(lUpR), .downRecv(lDnR),
    .done(aDone[1]), .failUp(aFu[1]), .failDown(aFd[1])
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (!rst_n) begin
        refSt[m] = 0; refIdx[m] = 0; refFu[m] = 1'b0; refFd[m] = 1'b0;
      end else begin
        case (refSt[m])
          0: if (start) begin refSt[m] = 1; refIdx[m] = 0; end
          1: begin
            logic [7:0] r;
            r = wireModel(expWord(m, 1'b1, 1, refIdx[m]), expWord(m, 1'b0, 1, refIdx[m]),
                          (m == 1) ? 4 : 3, fMask[m], fVal[m], fBr[m], fBrPos[m]);
            if ((^r[3:0]) != (m == 0)) refFu[m] = 1'b1;
            if (^r[7:4]) refFd[m] = 1'b1;
            if (refIdx[m] == ((m == 1) ? 7 : 3)) refSt[m] = 2;
            else refIdx[m] = refIdx[m] + 1;
          end
          default: refSt[m] = 0;
        endcase
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmpOn && rst_n) begin
      for (int m = 0; m < 2; m++) begin
        logic [3:0] eu;
        logic [3:0] ed;
        eu = expWord(m, 1'b1, refSt[m], refIdx[m]);
        ed = expWord(m, 1'b0, refSt[m], refIdx[m]);
        chk(aUp[m] == eu, (m == 1) ? "R3 up word" : "R1 up word", aUp[m], eu);
        chk(aDn[m] == ed, (m == 1) ? "R3 down word" : "R2 down word", aDn[m], ed);
        chk(aDone[m] == (refSt[m] == 2), "R7 done", aDone[m], refSt[m] == 2);
        chk(aFu[m] == refFu[m], "R4 failUp", aFu[m], refFu[m]);
        chk(aFd[m] == refFd[m], "R4 failDown", aFd[m], refFd[m]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulseStart();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic clearFaults();
    for (int m = 0; m < 2; m++) begin
      fMask[m] = 8'h00; fVal[m] = 8'h00; fBr[m] = 1'b0; fBrPos[m] = 0;
    end
  endtask

  task automatic plainSweep();
    pulseStart();
    for (int k = 1; k <= 12; k++) tick();
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    int doneS;
    int doneL;
    repeat (3) tick();
    // R10 reset state
    chk(aDone[0] == 0 && aFu[0] == 0 && aFd[0] == 0, "R10 short reset flags", aFu[0], 0);
    chk(aDone[1] == 0 && aFu[1] == 0 && aFd[1] == 0, "R10 long reset flags", aFu[1], 0);
    chk(aUp[0] == 4'h1 && aDn[0] == 4'h0, "R10 short idle words", aUp[0], 1);
    chk(aUp[1] == 4'h0 && aDn[1] == 4'h0, "R10 long idle words", aUp[1], 0);
    rst_n = 1'b1;
    cmpOn = 1'b1;
    tick();

    // R8 faults while idle must not flag
    fMask[0] = 8'h01; fVal[0] = 8'h00;
    fMask[1] = 8'h01; fVal[1] = 8'h01;
    repeat (5) tick();
    chk(!aFu[0] && !aFd[0] && !aFu[1] && !aFd[1], "R8 idle inputs ignored", aFu[0] | aFu[1], 0);
    clearFaults();

    // clean sweep with a start request in the middle (R7, R9)
    doneS = -1;
    doneL = -1;
    pulseStart();
    for (int k = 1; k <= 12; k++) begin
      tick();
      if (k == 2) start = 1'b1;
      if (k == 3) start = 1'b0;
      if (aDone[0] && doneS < 0) doneS = k;
      if (aDone[1] && doneL < 0) doneL = k;
    end
    chk(doneS == 4, "R7 short done cycle", doneS, 4);
    chk(doneL == 8, "R7 long done cycle", doneL, 8);
    chk(doneS == 4 && doneL == 8, "R9 mid-sweep start ignored", doneL, 8);
    chk(!aFu[0] && !aFd[0] && !aFu[1] && !aFd[1], "R4 clean sweep no fail", aFu[0], 0);

    // stuck faults: short up count msb stuck-1, long down parity stuck-0
    fMask[0] = 8'h10; fVal[0] = 8'h10;
    fMask[1] = 8'h02; fVal[1] = 8'h00;
    plainSweep();
    chk(aFu[0] && !aFd[0], "R4 short stuck flags up only", {aFu[0], aFd[0]}, 2);
    chk(!aFu[1] && aFd[1], "R4 long stuck flags down only", {aFu[1], aFd[1]}, 1);
    clearFaults();

    // R6 clean sweep keeps flags
    plainSweep();
    chk(aFu[0] && aFd[1], "R6 flags sticky across sweep", {aFu[0], aFd[1]}, 3);
    doReset();
    chk(!aFu[0] && !aFd[1], "R6 reset clears flags", {aFu[0], aFd[1]}, 0);

    // bridging between adjacent up/down wires
    fBr[0] = 1'b1; fBrPos[0] = 2;
    fBr[1] = 1'b1; fBrPos[1] = 0;
    plainSweep();
    chk(aFu[0] && aFd[0], "R4 short bridge both flags", {aFu[0], aFd[0]}, 3);
    clearFaults();
    doReset();

    // R5 fault only on the last short pattern; start in done cycle (R9)
    pulseStart();
    for (int k = 1; k <= 10; k++) begin
      tick();
      if (k == 3) begin
        chk(!aFu[0], "R5 no fail before last check", aFu[0], 0);
        fMask[0] = 8'h01; fVal[0] = 8'h00;
      end
      if (k == 4) begin
        chk(aFu[0] && aDone[0], "R5 fail with done same cycle", {aFu[0], aDone[0]}, 3);
        fMask[0] = 8'h00;
        start = 1'b1;
      end
      if (k == 5) begin
        start = 1'b0;
        chk(aUp[0] == 4'h1 && !aDone[0], "R9 start in done cycle ignored", aUp[0], 1);
      end
    end
    chk(!aFu[1] && !aFd[1], "R4 long unaffected", aFu[1], 0);

    cmpOn = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule